// File: doc/BRIEF.md
# Integer Compare and Carry Unit

This combinational unit sits in the execute stage of a small processor's ALU. It subtracts operand `a` from operand `b` and patches the top bit of the 32-bit difference. After the patch, that bit alone shows whether `b` is less than `a`. The comparison is signed or unsigned, as chosen by a mode pin. A branch or set-on-less-than path can then test a single bit, whatever the signs of the operands.

A second, independent output gives the carry-out of `a + b + cin`, for add-with-carry sequences.

The block has no storage. Every output follows the current inputs, and the mode pin is read together with the operands. The ports are plain data pins with no handshake, because the result is ready in the same cycle as its operands.

Top module: `cmpc_unit`

## Requirements
- R1: When bit 31 of `a` equals bit 31 of `b`, `cmp_result` equals `b - a` modulo 2^32 exactly, in either mode.
- R2: With `cmp_unsigned` = 0 (signed) and differing top bits, `cmp_result[30:0]` equals `(b - a)[30:0]` and `cmp_result[31]` equals `b[31]`.
- R3: With `cmp_unsigned` = 1 (unsigned) and differing top bits, `cmp_result[30:0]` equals `(b - a)[30:0]` and `cmp_result[31]` equals `a[31]`.
- R4: `cmp_result[31]` is 1 exactly when `b < a` under the selected interpretation (two's complement when `cmp_unsigned` = 0, unsigned when it is 1). For equal operands it is 0.
- R5: `carry_out` is 1 whenever `b` is all ones and `cin` is 1, whatever `a` is.
- R6: `carry_out` equals bit 32 of the 33-bit sum `a + b + cin` for every input.
- R7: When the top bits of `a` and `b` match, changing `cmp_unsigned` has no effect on `cmp_result`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | Subtrahend of the compare and first addend of the carry |
| op_b | input | 32 | Minuend of the compare and second addend of the carry |
| cmp_unsigned | input | 1 | 0 selects signed ordering, 1 selects unsigned ordering |
| cin | input | 1 | Carry-in for the carry computation |
| cmp_result | output | 32 | Difference `b - a` with its top bit corrected for ordering |
| carry_out | output | 1 | Carry-out of `a + b + cin` |

## Verification
The bench targets operand pairs whose signs differ in both directions. In that case the raw difference overflows, and a design that kept the raw top bit, or took it from the wrong operand, would invert the ordering. It also drives equal operands, the extreme values 0x80000000 and 0x7FFFFFFF, and a mode flip with matching signs. A design that leaked the mode into that path would change a result that must stay fixed. For the carry, it targets `b` all ones with `cin` set, and the sums that land exactly on 2^32 - 1 and 2^32. Those are where a carry rule that wraps `b + cin`, or uses the wrong comparison, gives a wrong carry.

// File: rtl/cmpc_pkg.sv
package cmpc_pkg;
  localparam int unsigned CMPC_WIDTH = 32;

  typedef enum logic {
    CMP_SIGNED   = 1'b0,
    CMP_UNSIGNED = 1'b1
  } cmp_mode_e;
endpackage

// File: rtl/cmpc_sub.sv
module cmpc_sub #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] minuend,
  input  logic [WIDTH-1:0] subtrahend,
  output logic [WIDTH-1:0] raw_diff,
  output logic             signs_differ
);
  localparam int unsigned TOP = WIDTH - 1;

  // Two's complement subtraction: minuend + ~subtrahend + 1
  always_comb begin
    raw_diff     = minuend + ~subtrahend + {{(WIDTH-1){1'b0}}, 1'b1};
    signs_differ = minuend[TOP] ^ subtrahend[TOP];
  end
endmodule

// File: rtl/cmpc_order_fix.sv
module cmpc_order_fix
  import cmpc_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] raw_diff,
  input  logic             signs_differ,
  input  logic             a_top,
  input  logic             b_top,
  input  cmp_mode_e        mode,
  output logic [WIDTH-1:0] fixed
);
  localparam int unsigned TOP = WIDTH - 1;

  logic top_sel;

  always_comb begin
    top_sel = (mode == CMP_UNSIGNED) ? a_top : b_top;
    fixed   = raw_diff;
    if (signs_differ) begin
      fixed[TOP] = top_sel;
    end
  end

  // Low bits never change: the patch touches the top bit only (R2, R3)
  always_comb begin
    assert_low_bits_kept_R2: assert (fixed[TOP-1:0] == raw_diff[TOP-1:0])
      else $error("low bits of compare result altered");
  end
endmodule

// File: rtl/cmpc_carry.sv
module cmpc_carry #(
  parameter int unsigned WIDTH     = 32,
  parameter bit          RULE_FORM = 1'b1
) (
  input  logic [WIDTH-1:0] add_a,
  input  logic [WIDTH-1:0] add_b,
  input  logic             cin,
  output logic             cout
);
  generate
    if (RULE_FORM) begin : g_rule
      // Headroom comparison: carry when the room left above a is smaller
      // than b + cin; the all-ones b with cin case is taken first because
      // b + cin wraps to zero there.
      logic [WIDTH-1:0] headroom;
      logic [WIDTH-1:0] addend;
      always_comb begin
        headroom = '1 - add_a;
        addend   = add_b + {{(WIDTH-1){1'b0}}, cin};
        if ((&add_b) && cin) begin
          cout = 1'b1;
        end else begin
          cout = (headroom < addend);
        end
      end
    end else begin : g_adder
      logic [WIDTH:0] sum_ext;
      always_comb begin
        sum_ext = {1'b0, add_a} + {1'b0, add_b} + {{WIDTH{1'b0}}, cin};
        cout    = sum_ext[WIDTH];
      end
    end
  endgenerate
endmodule

// File: rtl/cmpc_unit.sv
module cmpc_unit
  import cmpc_pkg::*;
#(
  parameter int unsigned WIDTH = CMPC_WIDTH
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             cmp_unsigned,
  input  logic             cin,
  output logic [WIDTH-1:0] cmp_result,
  output logic             carry_out
);
  localparam int unsigned TOP = WIDTH - 1;

  logic [WIDTH-1:0] raw_diff;
  logic             signs_differ;
  cmp_mode_e        mode;

  assign mode = cmp_mode_e'(cmp_unsigned);

  cmpc_sub #(.WIDTH(WIDTH)) u_sub (
    .minuend      (op_b),
    .subtrahend   (op_a),
    .raw_diff     (raw_diff),
    .signs_differ (signs_differ)
  );

  cmpc_order_fix #(.WIDTH(WIDTH)) u_fix (
    .raw_diff     (raw_diff),
    .signs_differ (signs_differ),
    .a_top        (op_a[TOP]),
    .b_top        (op_b[TOP]),
    .mode         (mode),
    .fixed        (cmp_result)
  );

  cmpc_carry #(.WIDTH(WIDTH), .RULE_FORM(1'b1)) u_carry (
    .add_a (op_a),
    .add_b (op_b),
    .cin   (cin),
    .cout  (carry_out)
  );

  // Cross-checks between the separately built pieces and the ports
  logic [WIDTH:0] chk_sum;
  logic           chk_less;

  always_comb begin
    chk_sum  = {1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, cin};
    chk_less = cmp_unsigned ? (op_b < op_a) : ($signed(op_b) < $signed(op_a));

    if (op_a[TOP] == op_b[TOP]) begin
      assert_same_sign_raw_R1: assert (cmp_result == op_b - op_a)
        else $error("same-sign result differs from raw difference");
    end
    assert_order_bit_R4: assert (cmp_result[TOP] == chk_less)
      else $error("top bit does not show ordering");
    if ((&op_b) && cin) begin
      assert_all_ones_carry_R5: assert (carry_out)
        else $error("all-ones b with cin gave no carry");
    end
    assert_carry_matches_sum_R6: assert (carry_out == chk_sum[WIDTH])
      else $error("carry differs from 33-bit sum");
  end
endmodule

// File: tb/cmpc_unit_tb_top.sv
`timescale 1ns/1ps
module cmpc_unit_tb_top;
  logic        clk = 1'b0;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic        cmp_unsigned = 1'b0;
  logic        cin = 1'b0;
  logic [31:0] cmp_result;
  logic        carry_out;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  cmpc_unit dut_i (
    .op_a         (op_a),
    .op_b         (op_b),
    .cmp_unsigned (cmp_unsigned),
    .cin          (cin),
    .cmp_result   (cmp_result),
    .carry_out    (carry_out)
  );

  function automatic logic [31:0] model_result(input logic [31:0] a, input logic [31:0] b,
                                               input logic uns);
    logic [31:0] d;
    d = b - a;
    if (a[31] != b[31]) d[31] = uns ? a[31] : b[31];
    return d;
  endfunction

  function automatic logic model_carry(input logic [31:0] a, input logic [31:0] b, input logic c);
    logic [32:0] s;
    s = {1'b0, a} + {1'b0, b} + {32'd0, c};
    return s[32];
  endfunction

  task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: a=%h b=%h uns=%0d actual=%h expected=%h",
               req, op_a, op_b, cmp_unsigned, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic uns, input logic c);
    @(negedge clk);
    op_a = a; op_b = b; cmp_unsigned = uns; cin = c;
    #1;
  endtask

  task automatic t_zero_start();
    apply(32'd0, 32'd0, 1'b0, 1'b0);
    check32("R1", cmp_result, 32'd0);
    check32("R6", {31'd0, carry_out}, 32'd0);
  endtask

  task automatic t_same_sign();
    apply(32'd10, 32'd3, 1'b0, 1'b0);
    check32("R1", cmp_result, 32'hFFFF_FFF9);
    apply(32'h8000_0005, 32'hFFFF_FFFF, 1'b1, 1'b0);
    check32("R1", cmp_result, 32'h7FFF_FFFA);
    apply(32'h1234_5678, 32'h1234_5678, 1'b1, 1'b0);
    check32("R4", {31'd0, cmp_result[31]}, 32'd0);
  endtask

  task automatic t_mode_no_effect();
    logic [31:0] r_s;
    apply(32'h9000_0000, 32'h8000_0001, 1'b0, 1'b0);
    r_s = cmp_result;
    apply(32'h9000_0000, 32'h8000_0001, 1'b1, 1'b0);
    check32("R7", cmp_result, r_s);
    check32("R7", cmp_result, 32'hF000_0001);
  endtask

  task automatic t_signed_differ();
    // b negative, a positive: b < a signed, top bit = b[31] = 1
    apply(32'h7FFF_FFFF, 32'h8000_0000, 1'b0, 1'b0);
    check32("R2", cmp_result, 32'h8000_0001);
    // b positive, a negative: raw diff top bit 1, corrected to b[31] = 0
    apply(32'h8000_0000, 32'h0000_0001, 1'b0, 1'b0);
    check32("R2", cmp_result, 32'h0000_0001);
    check32("R4", {31'd0, cmp_result[31]}, 32'd0);
  endtask

  task automatic t_unsigned_differ();
    apply(32'h7FFF_FFFF, 32'h8000_0000, 1'b1, 1'b0);
    check32("R3", cmp_result, 32'h0000_0001);
    apply(32'h8000_0000, 32'h0000_0001, 1'b1, 1'b0);
    check32("R3", cmp_result, 32'h8000_0001);
    check32("R4", {31'd0, cmp_result[31]}, 32'd1);
  endtask

  task automatic t_carry_corners();
    apply(32'd0, 32'hFFFF_FFFF, 1'b0, 1'b1);
    check32("R5", {31'd0, carry_out}, 32'd1);
    apply(32'd0, 32'hFFFF_FFFF, 1'b0, 1'b0);
    check32("R6", {31'd0, carry_out}, 32'd0);
    apply(32'd1, 32'hFFFF_FFFE, 1'b0, 1'b0);
    check32("R6", {31'd0, carry_out}, 32'd0);
    apply(32'd1, 32'hFFFF_FFFE, 1'b0, 1'b1);
    check32("R6", {31'd0, carry_out}, 32'd1);
    apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b1);
    check32("R5", {31'd0, carry_out}, 32'd1);
  endtask

  task automatic t_random();
    logic [31:0] a, b;
    logic u, c, less;
    for (int i = 0; i < 400; i++) begin
      a = $urandom; b = $urandom; u = 1'($urandom); c = 1'($urandom);
      if (i % 4 == 0) b[31] = ~a[31];
      apply(a, b, u, c);
      check32(a[31] == b[31] ? "R1" : (u ? "R3" : "R2"), cmp_result, model_result(a, b, u));
      less = u ? (b < a) : ($signed(b) < $signed(a));
      check32("R4", {31'd0, cmp_result[31]}, {31'd0, less});
      check32("R6", {31'd0, carry_out}, {31'd0, model_carry(a, b, c)});
    end
  endtask

  initial begin
    t_zero_start();
    t_same_sign();
    t_mode_no_effect();
    t_signed_differ();
    t_unsigned_differ();
    t_carry_corners();
    t_random();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end
endmodule